// File: doc/BRIEF.md
# Dual-Channel Down-Counting Event Timer

This block is a register-mapped timer with two independent channels. Each channel owns a 64-bit counter that falls by one on every tick of its own prescaled clock. Software loads the counter from a programmable 64-bit interval, starts it, and is told through a pending flag and a shared interrupt line when the count runs out. A channel runs either periodically, reloading itself and continuing, or as a one-shot that stops after its first expiry.

Access is through a single-cycle register port with a byte address, a write strobe, a read strobe and a registered read-data word. Two registers are shared by all channels: a per-channel interrupt mask at offset 0x00 and a write-one-to-clear pending register at 0x04, where bit n belongs to channel n. Channel n occupies five consecutive words starting at 0x10 + 0x20·n: control (+0x00), interval low (+0x04), interval high (+0x08), count low (+0x0C) and count high (+0x10). The control word holds enable in bit 0, reload request in bit 1, the prescaler exponent in bits 6:4 and the one-shot select in bit 7.

Stopping a channel is deliberately lazy: once enable is cleared, the channel keeps counting for two more of its own ticks before it halts. Software that reprograms a channel is expected to wait out this drain.

Top module: `evt_timer`

## Requirements
- R1: After a synchronous active-low reset, the irq output is low and the mask, pending, control, interval and count registers of every channel read as zero.
- R2: The interval words of each channel are read/write at their mapped offsets and read back exactly what was written.
- R3: With prescaler exponent p (control bits 6:4), a running channel ticks once every 2^p clock cycles, the first tick falling 2^p cycles after the write that enables it.
- R4: On each tick the count decreases by one, so successive reads of a running channel give a falling value.
- R5: In periodic mode (control bit 7 = 0) a tick that finds the count at 1 loads the interval into the count and the channel keeps running.
- R6: In one-shot mode (control bit 7 = 1) a tick that finds the count at 1 sets it to 0, clears the enable bit and stops the channel.
- R7: Each expiry sets that channel's pending bit; writing 1 to bit n of the pending register clears it, writing 0 leaves it, and an expiry in the same cycle as the clear wins.
- R8: irq is high exactly when some channel has both its pending bit and its mask bit (register 0x00, bit n) set; it follows the pending and mask registers with no extra cycle.
- R9: After enable is written to 0 on a running channel, enable reads back 0 at once but the count still falls on the next two ticks and then holds.
- R10: A write with the reload bit (control bit 1) set loads the interval into the count on that same clock edge if the channel was stopped, leaving the bit clear; if the channel was running, the bit reads back 1 until the next tick, which loads the interval instead of counting and clears the bit.
- R11: The count words are read-only, and writes to unmapped offsets (for example 0x08, 0x0C, 0x24) change no register; unmapped offsets read as zero.
- R12: Reading the count low word captures the count high word at that instant; a later read of count high returns the captured value even if the count has changed since.
- R13: A tick that finds the count at 0 leaves it at 0 and raises no expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers and counters |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Read data, valid from the clock edge that takes the read strobe |
| irq | output | 1 | Combined interrupt, high while any unmasked channel is pending |

## Verification
A register write takes effect on the clock edge that samples the strobe, and a read returns the value held just before the edge that samples it, so a read issued D idle cycles after an enabling write sees floor(D/2^p) ticks. The bench drives every access half a cycle before its edge and keeps the gaps between accesses explicit, so each expected count is computed from the number of edges elapsed and the prescaler exponent. Expiry, the pending bit and irq all change on the tick edge itself, so irq is sampled at the falling edge right after the predicted tick and one cycle earlier to show it is still low. The disable drain and the pending reload are checked with back-to-back reads placed on the edges just before and after the predicted tick.

// File: rtl/evt_timer_pkg.sv
// Package: shared constants and types for the event timer.
// Holds the control-word layout, register offsets and the channel word
// selector. Offsets and bit positions are fixed by the software view.
package evt_timer_pkg;

    localparam int CTL_PS_W      = 3;
    localparam int CTL_EN_POS    = 0;
    localparam int CTL_RLD_POS   = 1;
    localparam int CTL_PS_POS    = 4;
    localparam int CTL_OS_POS    = 7;

    localparam int OFS_IRQ_MASK  = 'h00;
    localparam int OFS_IRQ_PEND  = 'h04;
    localparam int OFS_CH_BASE   = 'h10;
    localparam int OFS_CH_STRIDE = 'h20;
    localparam int CH_WORDS      = 5;

    typedef enum logic [2:0] {
        W_CTL    = 3'd0,
        W_IVL_LO = 3'd1,
        W_IVL_HI = 3'd2,
        W_CNT_LO = 3'd3,
        W_CNT_HI = 3'd4
    } ch_word_e;

    typedef struct packed {
        logic                oneshot;
        logic [CTL_PS_W-1:0] presc;
        logic                reload;
        logic                en;
    } ctl_t;

    // Unpack the low byte of a control write into its fields.
    function automatic ctl_t ctl_from_byte(input logic [7:0] b);
        ctl_t c;
        c.en      = b[CTL_EN_POS];
        c.reload  = b[CTL_RLD_POS];
        c.presc   = b[CTL_PS_POS +: CTL_PS_W];
        c.oneshot = b[CTL_OS_POS];
        return c;
    endfunction

    // Pack the control fields back into their byte positions.
    function automatic logic [7:0] ctl_to_byte(input ctl_t c);
        logic [7:0] b;
        b                         = '0;
        b[CTL_EN_POS]             = c.en;
        b[CTL_RLD_POS]            = c.reload;
        b[CTL_PS_POS +: CTL_PS_W] = c.presc;
        b[CTL_OS_POS]             = c.oneshot;
        return b;
    endfunction

endpackage

// File: rtl/evt_tick_gen.sv
// Module: evt_tick_gen
// Produces a one-cycle tick enable every 2^presc cycles while run is high.
// Assumes presc may change at any time; the divider restarts from zero
// whenever run is low, so the first tick comes 2^presc cycles after run rises.
module evt_tick_gen
    import evt_timer_pkg::*;
#(
    parameter int PS_W = CTL_PS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] presc,
    output logic            tick
);

    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] bit_sel;
    logic [DIV_W-1:0] mask;

    // Mask of the low presc bits; a shift past the top wraps to all ones.
    always_comb begin
        bit_sel = DIV_W'(1) << presc;
        mask    = bit_sel - DIV_W'(1);
    end

    // Free-running divider, held at zero while the channel is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    assign tick = run && ((div_q & mask) == mask);

endmodule

// File: rtl/evt_channel.sv
// Module: evt_channel
// One timer channel: control word, 64-bit interval, 64-bit down counter,
// disable drain and expiry detection. Assumes write strobes are one cycle
// and mutually exclusive; expiry is a one-cycle pulse on the tick edge.
module evt_channel
    import evt_timer_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int STOP_TICKS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic                ivl_lo_we,
    input  logic                ivl_hi_we,
    input  logic [DATA_W-1:0]   wdata,
    output ctl_t                ctl_q,
    output logic [2*DATA_W-1:0] ivl_q,
    output logic [2*DATA_W-1:0] cnt_q,
    output logic                expire
);

    localparam int CNT_W = 2 * DATA_W;
    localparam int DRN_W = (STOP_TICKS > 1) ? $clog2(STOP_TICKS) : 1;

    ctl_t             wr_ctl;
    logic             active;
    logic [DRN_W-1:0] drain_q;
    logic             tick;
    logic             at_one;
    logic             at_zero;
    logic             os_stop;

    assign wr_ctl  = ctl_from_byte(wdata[7:0]);
    assign at_one  = (cnt_q == CNT_W'(1));
    assign at_zero = (cnt_q == '0);
    assign expire  = tick && !ctl_q.reload && at_one;
    assign os_stop = expire && ctl_q.oneshot;

    evt_tick_gen #(
        .PS_W (CTL_PS_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active),
        .presc (ctl_q.presc),
        .tick  (tick)
    );

    // Control register: software writes, reload and one-shot self-clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q.en      <= wr_ctl.en;
            ctl_q.presc   <= wr_ctl.presc;
            ctl_q.oneshot <= wr_ctl.oneshot;
            ctl_q.reload  <= wr_ctl.reload && active;
        end else begin
            if (tick && ctl_q.reload) begin
                ctl_q.reload <= 1'b0;
            end
            if (os_stop) begin
                ctl_q.en <= 1'b0;
            end
        end
    end

    // Run state: starts on enable, drains STOP_TICKS ticks after disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            drain_q <= '0;
        end else if (ctl_we && wr_ctl.en) begin
            active  <= 1'b1;
            drain_q <= '0;
        end else if (os_stop) begin
            active  <= 1'b0;
            drain_q <= '0;
        end else if (active && !ctl_q.en && tick) begin
            if (drain_q == DRN_W'(STOP_TICKS - 1)) begin
                active  <= 1'b0;
                drain_q <= '0;
            end else begin
                drain_q <= drain_q + DRN_W'(1);
            end
        end
    end

    // Interval register, written one word at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl_q <= '0;
        end else begin
            if (ivl_lo_we) begin
                ivl_q[DATA_W-1:0] <= wdata;
            end
            if (ivl_hi_we) begin
                ivl_q[CNT_W-1:DATA_W] <= wdata;
            end
        end
    end

    // Down counter: idle load, tick load, expiry reload or stop, decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ctl_we && wr_ctl.reload && !active) begin
            cnt_q <= ivl_q;
        end else if (tick) begin
            if (ctl_q.reload) begin
                cnt_q <= ivl_q;
            end else if (at_one) begin
                cnt_q <= ctl_q.oneshot ? '0 : ivl_q;
            end else if (!at_zero) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/evt_timer.sv
// Module: evt_timer (top)
// Register front end for NUM_CH timer channels: address decode, mask and
// pending registers, high-word capture on count-low reads, registered read
// data and the combined interrupt. Assumes single-cycle accesses and that
// the channel window fits inside the ADDR_W address space.
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int NUM_CH     = 2,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int STOP_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int CNT_W = 2 * DATA_W;

    logic [NUM_CH-1:0]              irq_mask;
    logic [NUM_CH-1:0]              irq_pend;
    logic [NUM_CH-1:0]              ch_hit;
    logic [NUM_CH-1:0][2:0]         ch_word;
    logic [NUM_CH-1:0]              ch_expire;
    ctl_t [NUM_CH-1:0]              ch_ctl;
    logic [NUM_CH-1:0][CNT_W-1:0]   ch_ivl;
    logic [NUM_CH-1:0][CNT_W-1:0]   ch_cnt;
    logic [NUM_CH-1:0][DATA_W-1:0]  hi_snap;
    logic [DATA_W-1:0]              rd_mux;
    logic                           mask_sel;
    logic                           pend_sel;

    assign mask_sel = (bus_addr == ADDR_W'(OFS_IRQ_MASK));
    assign pend_sel = (bus_addr == ADDR_W'(OFS_IRQ_PEND));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(OFS_CH_BASE + OFS_CH_STRIDE * n);
        logic [ADDR_W-1:0] rel;

        // Window decode: five aligned words from this channel's base.
        assign rel        = bus_addr - BASE;
        assign ch_hit[n]  = (bus_addr >= BASE) && (rel < ADDR_W'(4 * CH_WORDS)) &&
                            (rel[1:0] == 2'b00);
        assign ch_word[n] = rel[4:2];

        evt_channel #(
            .DATA_W     (DATA_W),
            .STOP_TICKS (STOP_TICKS)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_we    (bus_wr && ch_hit[n] && (ch_word[n] == W_CTL)),
            .ivl_lo_we (bus_wr && ch_hit[n] && (ch_word[n] == W_IVL_LO)),
            .ivl_hi_we (bus_wr && ch_hit[n] && (ch_word[n] == W_IVL_HI)),
            .wdata     (bus_wdata),
            .ctl_q     (ch_ctl[n]),
            .ivl_q     (ch_ivl[n]),
            .cnt_q     (ch_cnt[n]),
            .expire    (ch_expire[n])
        );

        // Capture the high count word when software reads the low word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_snap[n] <= '0;
            end else if (bus_rd && ch_hit[n] && (ch_word[n] == W_CNT_LO)) begin
                hi_snap[n] <= ch_cnt[n][CNT_W-1:DATA_W];
            end
        end

        // Pending flag: set by expiry, cleared by writing one, set wins.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_pend[n] <= 1'b0;
            end else if (ch_expire[n]) begin
                irq_pend[n] <= 1'b1;
            end else if (bus_wr && pend_sel && bus_wdata[n]) begin
                irq_pend[n] <= 1'b0;
            end
        end
    end

    // Interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_mask <= '0;
        end else if (bus_wr && mask_sel) begin
            irq_mask <= bus_wdata[NUM_CH-1:0];
        end
    end

    // Read multiplexer over shared and per-channel words.
    always_comb begin
        rd_mux = '0;
        if (mask_sel) begin
            rd_mux = DATA_W'(irq_mask);
        end else if (pend_sel) begin
            rd_mux = DATA_W'(irq_pend);
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (ch_hit[n]) begin
                case (ch_word[n])
                    W_CTL:    rd_mux = DATA_W'(ctl_to_byte(ch_ctl[n]));
                    W_IVL_LO: rd_mux = ch_ivl[n][DATA_W-1:0];
                    W_IVL_HI: rd_mux = ch_ivl[n][CNT_W-1:DATA_W];
                    W_CNT_LO: rd_mux = ch_cnt[n][DATA_W-1:0];
                    W_CNT_HI: rd_mux = hi_snap[n];
                    default:  rd_mux = '0;
                endcase
            end
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    assign irq = |(irq_pend & irq_mask);

endmodule

// File: rtl/evt_timer_chk.sv
// Module: evt_timer_chk
// Property checker bound to evt_timer. Observes the bus, the mask and
// pending registers and each channel's control, interval, count and expiry.
module evt_timer_chk
    import evt_timer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic [ADDR_W-1:0]                  bus_addr,
    input logic [DATA_W-1:0]                  bus_wdata,
    input logic                               bus_wr,
    input logic                               irq,
    input logic [NUM_CH-1:0]                  irq_mask,
    input logic [NUM_CH-1:0]                  irq_pend,
    input logic [NUM_CH-1:0]                  ch_expire,
    input ctl_t [NUM_CH-1:0]                  ch_ctl,
    input logic [NUM_CH-1:0][2*DATA_W-1:0]    ch_ivl,
    input logic [NUM_CH-1:0][2*DATA_W-1:0]    ch_cnt
);

    // Reset leaves the interrupt quiet and nothing pending.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq && (irq_pend == '0)));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        // Periodic expiry restarts the count from the interval.
        assert_periodic_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_expire[n] && !ch_ctl[n].oneshot) |=> (ch_cnt[n] == $past(ch_ivl[n])));

        // Expiry only happens when the count stands at one.
        assert_expire_at_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ch_expire[n] |-> (ch_cnt[n] == (2*DATA_W)'(1)));

        // One-shot expiry clears enable and leaves the count at zero.
        assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_expire[n] && ch_ctl[n].oneshot && !bus_wr) |=>
                (!ch_ctl[n].en && (ch_cnt[n] == '0)));

        // Expiry raises the pending bit on the next cycle.
        assert_expire_pends_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ch_expire[n] |=> irq_pend[n]);

        // Writing one clears the pending bit unless an expiry coincides.
        assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && (bus_addr == ADDR_W'(OFS_IRQ_PEND)) && bus_wdata[n] && !ch_expire[n])
                |=> !irq_pend[n]);

        // An unmasked expiry drives the interrupt high next cycle.
        assert_irq_raised_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_expire[n] && irq_mask[n] && !(bus_wr && (bus_addr == ADDR_W'(OFS_IRQ_MASK))))
                |=> irq);
    end

    // Interrupt is never high with nothing pending.
    assert_irq_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_pend != '0));

endmodule

bind evt_timer evt_timer_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .irq       (irq),
    .irq_mask  (irq_mask),
    .irq_pend  (irq_pend),
    .ch_expire (ch_expire),
    .ch_ctl    (ch_ctl),
    .ch_ivl    (ch_ivl),
    .ch_cnt    (ch_cnt)
);

// File: tb/evt_timer_tb_top.sv
// Bench for evt_timer: sweeps every prescaler on both channels and walks
// the expiry, pending, disable-drain, reload and capture corner cases.
// All accesses are driven at the falling edge; each lands on the next rising edge.
module evt_timer_tb_top;

    logic        clk;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_wr;
    logic        bus_rd;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk;
    int n_err;

    evt_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, {32'h0, d}, {32'h0, exp});
    endtask

    // Watchdog: a hung run is one failed check and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        n_chk     = 0;
        n_err     = 0;
        rst_n     = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", {63'h0, irq}, 64'h0);
        rdchk("R1 mask", 8'h00, 32'h0);
        rdchk("R1 pending", 8'h04, 32'h0);
        rdchk("R1 ctl ch0", 8'h10, 32'h0);
        rdchk("R1 ivl ch1", 8'h34, 32'h0);
        rdchk("R1 cnt ch1", 8'h3C, 32'h0);

        // R2: interval words read back
        wr(8'h34, 32'hDEADBEEF);
        wr(8'h38, 32'h01234567);
        wr(8'h18, 32'h00C0FFEE);
        rdchk("R2 ivl lo ch1", 8'h34, 32'hDEADBEEF);
        rdchk("R2 ivl hi ch1", 8'h38, 32'h01234567);
        rdchk("R2 ivl hi ch0", 8'h18, 32'h00C0FFEE);

        // R3/R4/R5: prescaler sweep, periodic interval 5, T = p+4 ticks
        for (int c = 0; c < 2; c++) begin
            for (int p = 0; p < 8; p++) begin
                logic [7:0] base;
                int         t;
                base = 8'(8'h10 + 8'h20 * c);
                t    = p + 4;
                wr(base, 32'h0);
                repeat (4) @(negedge clk);
                wr(8'(base + 8'h04), 32'd5);
                wr(8'(base + 8'h08), 32'd0);
                wr(base, 32'h3 | 32'(p << 4));
                repeat (t * (1 << p)) @(negedge clk);
                rdchk($sformatf("R3 R4 R5 ch%0d p%0d count", c, p), 8'(base + 8'h0C),
                      32'(5 - (t % 5)));
            end
            wr(8'(8'h10 + 8'h20 * c), 32'h0);
            repeat (4) @(negedge clk);
        end

        // R6/R8: one-shot on ch0, interval 4, prescaler 0
        wr(8'h04, 32'h3);
        wr(8'h00, 32'h3);
        chk("R8 irq low after clear", {63'h0, irq}, 64'h0);
        wr(8'h14, 32'd4);
        wr(8'h18, 32'd0);
        wr(8'h10, 32'h83);
        repeat (3) @(negedge clk);
        chk("R8 irq low before expiry", {63'h0, irq}, 64'h0);
        @(negedge clk);
        chk("R8 irq high at expiry", {63'h0, irq}, 64'h1);
        rdchk("R6 enable cleared", 8'h10, 32'h80);
        rdchk("R6 count zero", 8'h1C, 32'h0);
        repeat (20) @(negedge clk);
        rdchk("R6 count stays zero", 8'h1C, 32'h0);
        rdchk("R7 pending set", 8'h04, 32'h1);

        // R7/R8: write-one-to-clear on the pending register
        wr(8'h04, 32'h2);
        rdchk("R7 other bit write keeps pending", 8'h04, 32'h1);
        chk("R8 irq still high", {63'h0, irq}, 64'h1);
        wr(8'h04, 32'h1);
        chk("R8 irq low after clear", {63'h0, irq}, 64'h0);
        rdchk("R7 pending cleared", 8'h04, 32'h0);

        // R8: masked channel pends without raising irq
        wr(8'h00, 32'h2);
        wr(8'h10, 32'h83);
        repeat (10) @(negedge clk);
        chk("R8 masked irq low", {63'h0, irq}, 64'h0);
        rdchk("R7 masked still pends", 8'h04, 32'h1);
        wr(8'h00, 32'h3);
        chk("R8 unmask raises irq", {63'h0, irq}, 64'h1);
        wr(8'h04, 32'h1);

        // R5/R7: ch1 periodic interval 3, expiries every 3 edges; clear vs set
        wr(8'h34, 32'd3);
        wr(8'h38, 32'd0);
        wr(8'h30, 32'h3);
        repeat (4) @(negedge clk);
        rdchk("R5 periodic pends", 8'h04, 32'h2);
        wr(8'h04, 32'h2);
        rdchk("R7 expiry beats clear", 8'h04, 32'h2);
        wr(8'h04, 32'h2);
        rdchk("R7 clear between expiries", 8'h04, 32'h0);
        wr(8'h30, 32'h0);
        repeat (6) @(negedge clk);
        wr(8'h04, 32'h3);

        // R9: disable drain on ch0, periodic, prescaler 1, interval 100
        wr(8'h14, 32'd100);
        wr(8'h10, 32'h13);
        repeat (9) @(negedge clk);
        wr(8'h10, 32'h10);
        rdchk("R9 enable reads zero", 8'h10, 32'h10);
        rdchk("R9 count before drain tick", 8'h1C, 32'd95);
        rdchk("R9 count falls during drain", 8'h1C, 32'd94);
        repeat (50) @(negedge clk);
        rdchk("R9 count halts after two ticks", 8'h1C, 32'd93);
        repeat (20) @(negedge clk);
        rdchk("R9 count stays halted", 8'h1C, 32'd93);

        // R10: reload while running, prescaler 2, interval 50 then 7
        wr(8'h14, 32'd50);
        wr(8'h10, 32'h23);
        repeat (20) @(negedge clk);
        wr(8'h14, 32'd7);
        wr(8'h10, 32'h23);
        rdchk("R10 reload pending", 8'h10, 32'h23);
        rdchk("R10 count before tick", 8'h1C, 32'd45);
        rdchk("R10 tick loads interval", 8'h1C, 32'd7);
        rdchk("R10 reload bit cleared", 8'h10, 32'h21);
        wr(8'h10, 32'h0);
        repeat (10) @(negedge clk);

        // R12/R10: idle load and high-word capture on ch1
        wr(8'h34, 32'h12);
        wr(8'h38, 32'hA5);
        wr(8'h30, 32'h2);
        rdchk("R10 idle reload clears bit", 8'h30, 32'h0);
        rdchk("R12 count lo", 8'h3C, 32'h12);
        rdchk("R12 count hi", 8'h40, 32'hA5);
        rdchk("R12 capture lo", 8'h3C, 32'h12);
        wr(8'h38, 32'h5A);
        wr(8'h30, 32'h2);
        rdchk("R12 hi keeps captured value", 8'h40, 32'hA5);
        rdchk("R12 lo recapture", 8'h3C, 32'h12);
        rdchk("R12 hi after recapture", 8'h40, 32'h5A);

        // R11: read-only count words and unmapped offsets
        wr(8'h3C, 32'hFFFFFFFF);
        wr(8'h40, 32'hFFFFFFFF);
        rdchk("R11 count lo read-only", 8'h3C, 32'h12);
        rdchk("R11 count hi read-only", 8'h40, 32'h5A);
        wr(8'h08, 32'hFF);
        wr(8'h0C, 32'hFF);
        wr(8'h24, 32'hFF);
        wr(8'h44, 32'hFF);
        rdchk("R11 mask untouched", 8'h00, 32'h3);
        rdchk("R11 pending untouched", 8'h04, 32'h0);
        rdchk("R11 ctl ch0 untouched", 8'h10, 32'h0);
        rdchk("R11 ivl ch0 untouched", 8'h14, 32'd7);
        rdchk("R11 unmapped reads zero", 8'h08, 32'h0);
        chk("R11 irq untouched", {63'h0, irq}, 64'h0);

        // R13: zero count never expires
        wr(8'h34, 32'h0);
        wr(8'h38, 32'h0);
        wr(8'h30, 32'h83);
        repeat (20) @(negedge clk);
        rdchk("R13 no expiry from zero", 8'h04, 32'h0);
        rdchk("R13 count stays zero", 8'h3C, 32'h0);
        rdchk("R13 enable kept", 8'h30, 32'h81);
        wr(8'h30, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule